// File: doc/BRIEF.md
# Halt Cycle and Wake Controller

This block sits inside a processor's bus interface and carries out the halt sequence. When the execution unit requests a halt, the block stalls the execution unit and runs exactly one halt bus cycle of two clock phases, T1 and T2. It then keeps the bus interface parked in a suspended state until a wake event qualifies under the current power mode. During the halt cycle it sets whether the multiplexed address/data bus floats or drives in T1, and what the upper address lines carry. It also blocks the internally decoded chip-selects.

Wake qualification depends on the 2-bit power mode input. An interrupt ends suspension in every mode. A bus hold request, a DMA request or a memory refresh request ends suspension only when the mode is not powerdown. On wake, the block gives the execution unit a one-cycle resume pulse and a vector naming the events that caused the wake, so they can be serviced. The bus drive during T1 is a pure function of the bus cycle captured when the halt was accepted, so a given instruction sequence always produces the same halt-cycle bus activity.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycles after it, eu_stall_o, resume_o, ad_oe_o and cs_mask_o are 0, wake_src_o, ad_o and ahi_o are 0, and status_o is the passive code 3'b111.
- R2: A halt_req_i sampled high while running moves the block to T1 on the next clock: eu_stall_o rises and status_o carries the halt code 3'b011 for exactly that one cycle. T2 follows with status_o passive, and the block then enters suspension with eu_stall_o still 1.
- R3: cs_mask_o is 1 in T1 and T2 of the halt cycle and 0 in every other state.
- R4: When the bus cycle before the halt was not a write (prev_write_i low when the halt is accepted), the address/data bus floats in T1: ad_oe_o is 0 and ad_o is 0.
- R5: When the halt directly follows a write (prev_write_i high when the halt is accepted), ad_oe_o is 1 in T1 only, and ad_o carries the wr_data_i word captured when the halt was accepted.
- R6: In T1 and T2, ahi_o carries the captured prev_ahi_i value when no write preceded the halt, and the captured next_ahi_i (next prefetch) value when a write preceded it. In all other states ahi_o is 0.
- R7: In suspension, irq_i wakes the block in every power mode (00 active, 01 idle, 10 powerdown, 11 treated as active).
- R8: In suspension, hold_i, dma_i and refresh_i each wake the block when pmode_i is not 2'b10. When pmode_i is 2'b10 they are ignored: the block stays suspended, with resume_o 0 and eu_stall_o 1.
- R9: A wake enters a WAKE state for one cycle. In that cycle resume_o is 1, eu_stall_o is 0, and wake_src_o holds one bit per qualifying event (bit 0 interrupt, bit 1 hold, bit 2 DMA, bit 3 refresh). The block then returns to running, with resume_o and wake_src_o back at 0.
- R10: halt_req_i outside the running state has no effect, and wake events present during T1 or T2 do not shorten the halt cycle.
- R11: Repeating the same halt sequence with the same inputs produces identical outputs cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| halt_req_i | input | 1 | Halt request from the execution unit |
| pmode_i | input | 2 | Power mode: 00 active, 01 idle, 10 powerdown, 11 as active |
| prev_write_i | input | 1 | Previous bus cycle was a write |
| wr_data_i | input | AD_W | Word left on the address/data bus by the previous write |
| prev_ahi_i | input | AHI_W | Upper address of the previous bus cycle |
| next_ahi_i | input | AHI_W | Upper address of the next prefetch |
| irq_i | input | 1 | Interrupt request |
| hold_i | input | 1 | Bus hold request |
| dma_i | input | 1 | DMA request |
| refresh_i | input | 1 | Memory refresh request |
| eu_stall_o | output | 1 | Execution unit suspended |
| resume_o | output | 1 | One-cycle resume pulse |
| wake_src_o | output | 4 | Events that caused the wake, valid with resume_o |
| ad_oe_o | output | 1 | Address/data bus drive enable |
| ad_o | output | AD_W | Address/data bus value |
| ahi_o | output | AHI_W | Upper address lines |
| status_o | output | 3 | Bus status code |
| cs_mask_o | output | 1 | Forces internal chip-selects inactive |

## Verification
The bench aims at the powerdown mask. Here a design that lets hold, DMA or refresh through would resume early, and one that also masks the interrupt would never resume. It checks T1 bus drive after a write against a float after a read, which catches a block that drives always or never, or one that swaps the upper address sources. It asserts wake events during T1 and T2 and a halt request during suspension, which expose a state machine that cuts the halt cycle short or restarts it. It also checks the width of the resume pulse and the contents of the source vector, including events that arrive together.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_IDLE   = 2'b01,
    PM_PDOWN  = 2'b10,
    PM_RSVD   = 2'b11
  } pmode_e;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_HALT_T1 = 3'd1,
    ST_HALT_T2 = 3'd2,
    ST_SUSP    = 3'd3,
    ST_WAKE    = 3'd4
  } state_e;

  localparam int unsigned NUM_WAKE = 4;
  localparam int unsigned WK_IRQ   = 0;
  localparam int unsigned WK_HOLD  = 1;
  localparam int unsigned WK_DMA   = 2;
  localparam int unsigned WK_RFSH  = 3;

  localparam int unsigned STAT_W       = 3;
  localparam logic [STAT_W-1:0] STAT_HALT    = 3'b011;
  localparam logic [STAT_W-1:0] STAT_PASSIVE = 3'b111;
endpackage

// File: rtl/halt_wake_qual.sv
module halt_wake_qual
  import halt_pkg::*;
(
  input  logic [1:0]          pmode_i,
  input  logic [NUM_WAKE-1:0] evt_i,
  output logic [NUM_WAKE-1:0] wake_vec_o,
  output logic                wake_any_o
);
  logic pdown;
  assign pdown = (pmode_i == PM_PDOWN);

  // bit WK_IRQ always qualifies; the rest are masked in powerdown
  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_qual
    if (i == WK_IRQ) begin : g_always
      assign wake_vec_o[i] = evt_i[i];
    end else begin : g_gated
      assign wake_vec_o[i] = evt_i[i] & ~pdown;
    end
  end

  assign wake_any_o = |wake_vec_o;
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                halt_req_i,
  input  logic                wake_any_i,
  input  logic [NUM_WAKE-1:0] wake_vec_i,
  output state_e              state_o,
  output logic                capture_o,
  output logic                resume_o,
  output logic [NUM_WAKE-1:0] wake_src_o
);
  state_e state_q, state_d;
  logic [NUM_WAKE-1:0] src_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (halt_req_i) state_d = ST_HALT_T1;
      ST_HALT_T1: state_d = ST_HALT_T2;
      ST_HALT_T2: state_d = ST_SUSP;
      ST_SUSP:    if (wake_any_i) state_d = ST_WAKE;
      ST_WAKE:    state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      src_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SUSP && wake_any_i) src_q <= wake_vec_i;
      else if (state_q == ST_WAKE)          src_q <= '0;
    end
  end

  assign state_o    = state_q;
  assign capture_o  = (state_q == ST_RUN) && halt_req_i;
  assign resume_o   = (state_q == ST_WAKE);
  assign wake_src_o = (state_q == ST_WAKE) ? src_q : '0;
endmodule

// File: rtl/halt_bus_drive.sv
module halt_bus_drive
  import halt_pkg::*;
#(
  parameter int unsigned AD_W  = 16,
  parameter int unsigned AHI_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  state_e            state_i,
  input  logic              prev_write_i,
  input  logic [AD_W-1:0]   wr_data_i,
  input  logic [AHI_W-1:0]  prev_ahi_i,
  input  logic [AHI_W-1:0]  next_ahi_i,
  output logic              ad_oe_o,
  output logic [AD_W-1:0]   ad_o,
  output logic [AHI_W-1:0]  ahi_o,
  output logic [STAT_W-1:0] status_o,
  output logic              cs_mask_o
);
  logic             wr_q;
  logic [AD_W-1:0]  data_q;
  logic [AHI_W-1:0] ahi_q;
  logic             in_t1, in_cycle;

  // context is frozen at acceptance so the halt cycle is repeatable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      ahi_q  <= '0;
    end else if (capture_i) begin
      wr_q   <= prev_write_i;
      data_q <= wr_data_i;
      ahi_q  <= prev_write_i ? next_ahi_i : prev_ahi_i;
    end
  end

  assign in_t1    = (state_i == ST_HALT_T1);
  assign in_cycle = in_t1 || (state_i == ST_HALT_T2);

  assign ad_oe_o   = in_t1 && wr_q;
  assign ad_o      = ad_oe_o ? data_q : '0;
  assign ahi_o     = in_cycle ? ahi_q : '0;
  assign status_o  = in_t1 ? STAT_HALT : STAT_PASSIVE;
  assign cs_mask_o = in_cycle;
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_pkg::*;
#(
  parameter int unsigned AD_W  = 16,
  parameter int unsigned AHI_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                halt_req_i,
  input  logic [1:0]          pmode_i,
  input  logic                prev_write_i,
  input  logic [AD_W-1:0]     wr_data_i,
  input  logic [AHI_W-1:0]    prev_ahi_i,
  input  logic [AHI_W-1:0]    next_ahi_i,
  input  logic                irq_i,
  input  logic                hold_i,
  input  logic                dma_i,
  input  logic                refresh_i,
  output logic                eu_stall_o,
  output logic                resume_o,
  output logic [NUM_WAKE-1:0] wake_src_o,
  output logic                ad_oe_o,
  output logic [AD_W-1:0]     ad_o,
  output logic [AHI_W-1:0]    ahi_o,
  output logic [STAT_W-1:0]   status_o,
  output logic                cs_mask_o
);
  logic [NUM_WAKE-1:0] evt, wake_vec;
  logic                wake_any, capture;
  state_e              state_q;

  assign evt[WK_IRQ]  = irq_i;
  assign evt[WK_HOLD] = hold_i;
  assign evt[WK_DMA]  = dma_i;
  assign evt[WK_RFSH] = refresh_i;

  halt_wake_qual i_qual (
    .pmode_i    (pmode_i),
    .evt_i      (evt),
    .wake_vec_o (wake_vec),
    .wake_any_o (wake_any)
  );

  halt_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_req_i (halt_req_i),
    .wake_any_i (wake_any),
    .wake_vec_i (wake_vec),
    .state_o    (state_q),
    .capture_o  (capture),
    .resume_o   (resume_o),
    .wake_src_o (wake_src_o)
  );

  halt_bus_drive #(.AD_W(AD_W), .AHI_W(AHI_W)) i_drive (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .capture_i    (capture),
    .state_i      (state_q),
    .prev_write_i (prev_write_i),
    .wr_data_i    (wr_data_i),
    .prev_ahi_i   (prev_ahi_i),
    .next_ahi_i   (next_ahi_i),
    .ad_oe_o      (ad_oe_o),
    .ad_o         (ad_o),
    .ahi_o        (ahi_o),
    .status_o     (status_o),
    .cs_mask_o    (cs_mask_o)
  );

  assign eu_stall_o = (state_q == ST_HALT_T1) || (state_q == ST_HALT_T2)
                   || (state_q == ST_SUSP);
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk
  import halt_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          state_q,
  input logic                halt_req_i,
  input logic [1:0]          pmode_i,
  input logic                irq_i,
  input logic                eu_stall_o,
  input logic                resume_o,
  input logic [NUM_WAKE-1:0] wake_src_o,
  input logic                ad_oe_o,
  input logic [STAT_W-1:0]   status_o,
  input logic                cs_mask_o
);
  // R2
  halt_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && halt_req_i) |=> (status_o == STAT_HALT && eu_stall_o));

  // R2
  halt_code_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == STAT_HALT) |=> (status_o == STAT_PASSIVE && cs_mask_o));

  // R3
  cs_mask_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_mask_o |-> (state_q == ST_HALT_T1 || state_q == ST_HALT_T2));

  // R5
  ad_drive_t1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> (status_o == STAT_HALT));

  // R7
  irq_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && irq_i) |=> resume_o);

  // R8
  pdown_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP && pmode_i == PM_PDOWN && !irq_i) |=> (!resume_o && eu_stall_o));

  // R9
  resume_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  // R9
  resume_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> ($countones(wake_src_o) > 0 && !eu_stall_o));
endmodule

bind halt_wake_ctrl halt_wake_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_q    (state_q),
  .halt_req_i (halt_req_i),
  .pmode_i    (pmode_i),
  .irq_i      (irq_i),
  .eu_stall_o (eu_stall_o),
  .resume_o   (resume_o),
  .wake_src_o (wake_src_o),
  .ad_oe_o    (ad_oe_o),
  .status_o   (status_o),
  .cs_mask_o  (cs_mask_o)
);

// File: tb/test_halt_wake_ctrl.sv
`timescale 1ns/1ps
module test_halt_wake_ctrl;
  localparam int AD_W  = 16;
  localparam int AHI_W = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_req_i = 1'b0;
  logic [1:0] pmode_i = 2'b00;
  logic prev_write_i = 1'b0;
  logic [AD_W-1:0] wr_data_i = '0;
  logic [AHI_W-1:0] prev_ahi_i = '0, next_ahi_i = '0;
  logic irq_i = 1'b0, hold_i = 1'b0, dma_i = 1'b0, refresh_i = 1'b0;
  logic eu_stall_o, resume_o, ad_oe_o, cs_mask_o;
  logic [3:0] wake_src_o;
  logic [AD_W-1:0] ad_o;
  logic [AHI_W-1:0] ahi_o;
  logic [2:0] status_o;

  always #10 clk_i = ~clk_i;

  halt_wake_ctrl #(.AD_W(AD_W), .AHI_W(AHI_W)) i_halt_wake_ctrl (.*);

  typedef struct {
    logic stall, resume, oe, cs;
    logic [3:0] src;
    logic [AD_W-1:0] ad;
    logic [AHI_W-1:0] ahi;
    logic [2:0] stat;
    string tag;
  } exp_t;

  exp_t q[$];
  int nchk = 0, nerr = 0;

  function automatic exp_t mk(logic stall, logic resume, logic oe, logic cs, logic [3:0] src,
                              logic [AD_W-1:0] ad, logic [AHI_W-1:0] ahi, logic [2:0] stat,
                              string tag);
    exp_t e;
    e.stall = stall; e.resume = resume; e.oe = oe; e.cs = cs; e.src = src;
    e.ad = ad; e.ahi = ahi; e.stat = stat; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t e_run(string t);  return mk(0,0,0,0,4'h0,'0,'0,3'b111,t); endfunction
  function automatic exp_t e_susp(string t); return mk(1,0,0,0,4'h0,'0,'0,3'b111,t); endfunction
  function automatic exp_t e_t1(logic wr, logic [AD_W-1:0] d, logic [AHI_W-1:0] h, string t);
    return mk(1,0,wr,1,4'h0, wr ? d : '0, h, 3'b011, t);
  endfunction
  function automatic exp_t e_t2(logic [AHI_W-1:0] h, string t);
    return mk(1,0,0,1,4'h0,'0,h,3'b111,t);
  endfunction
  function automatic exp_t e_wake(logic [3:0] s, string t); return mk(0,1,0,0,s,'0,'0,3'b111,t); endfunction

  task automatic compare(exp_t e);
    nchk++;
    if (eu_stall_o !== e.stall || resume_o !== e.resume || ad_oe_o !== e.oe ||
        cs_mask_o !== e.cs || wake_src_o !== e.src || ad_o !== e.ad ||
        ahi_o !== e.ahi || status_o !== e.stat) begin
      nerr++;
      $display("FAIL %s: act stall=%b res=%b oe=%b cs=%b src=%h ad=%h ahi=%h st=%b exp stall=%b res=%b oe=%b cs=%b src=%h ad=%h ahi=%h st=%b",
               e.tag, eu_stall_o, resume_o, ad_oe_o, cs_mask_o, wake_src_o, ad_o, ahi_o, status_o,
               e.stall, e.resume, e.oe, e.cs, e.src, e.ad, e.ahi, e.stat);
    end
  endtask

  // monitor: one expectation per clock, sampled after the edge
  initial forever begin
    @(posedge clk_i);
    #5;
    if (q.size() > 0) compare(q.pop_front());
  end

  // driver: apply inputs at negedge, push what the next edge must produce
  task automatic cyc(logic hreq, logic irq, logic hold, logic dma, logic rfs, exp_t e);
    @(negedge clk_i);
    halt_req_i = hreq; irq_i = irq; hold_i = hold; dma_i = dma; refresh_i = rfs;
    q.push_back(e);
  endtask

  task automatic do_halt(logic wr, logic [AD_W-1:0] d, logic [AHI_W-1:0] ph,
                         logic [AHI_W-1:0] nh, string t);
    logic [AHI_W-1:0] h;
    h = wr ? nh : ph;
    @(negedge clk_i);
    prev_write_i = wr; wr_data_i = d; prev_ahi_i = ph; next_ahi_i = nh;
    cyc(1, 0,0,0,0, e_t1(wr, d, h, t));
    cyc(0, 0,0,0,0, e_t2(h, t));
    cyc(0, 0,0,0,0, e_susp(t));
  endtask

  initial begin
    #(20 * 200000);
    nerr++;
    $display("FAIL watchdog: act running exp finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #15;
    compare(e_run("R1 in reset"));
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(0,0,0,0,0, e_run("R1 after reset"));
    cyc(0,0,0,0,0, e_run("R1 idle"));

    // R2 R3 R4 R6: halt after a read, wake by hold in idle (R8, R9)
    pmode_i = 2'b01;
    do_halt(0, 16'h1234, 4'hA, 4'h5, "R2 R3 R4 R6 read-halt");
    cyc(0,0,1,0,0, e_wake(4'b0010, "R8 R9 hold wake idle"));
    cyc(0,0,0,0,0, e_run("R9 back to run"));

    // R5 R6: halt after a write, powerdown masks secondaries (R8)
    pmode_i = 2'b10;
    do_halt(1, 16'hBEEF, 4'hA, 4'h5, "R5 R6 write-halt");
    cyc(0,0,1,0,0, e_susp("R8 hold ignored pdown"));
    cyc(0,0,0,1,0, e_susp("R8 dma ignored pdown"));
    cyc(0,0,0,0,1, e_susp("R8 refresh ignored pdown"));
    cyc(1,0,0,0,0, e_susp("R10 halt_req ignored in susp"));
    cyc(0,1,0,1,0, e_wake(4'b0001, "R7 R9 irq wake pdown"));
    cyc(0,0,0,0,0, e_run("R9 run after pdown"));

    // R8 R7: mode 11 acts as active; combined events
    pmode_i = 2'b11;
    do_halt(0, 16'h0000, 4'h3, 4'hC, "R6 read-halt mode11");
    cyc(0,1,0,1,1, e_wake(4'b1101, "R7 R8 R9 combined mode11"));
    cyc(0,0,0,0,0, e_run("R9 run"));

    // R10: events in T1/T2 do not shorten the halt cycle
    pmode_i = 2'b00;
    @(negedge clk_i); prev_write_i = 0; prev_ahi_i = 4'h7; next_ahi_i = 4'h1;
    cyc(1,1,1,0,0, e_t1(0, '0, 4'h7, "R10 T1 with events"));
    cyc(0,1,1,0,0, e_t2(4'h7, "R10 T2 with events"));
    cyc(0,0,0,0,0, e_susp("R10 enters susp"));
    cyc(0,0,0,1,0, e_wake(4'b0100, "R8 R9 dma wake active"));
    cyc(0,0,0,0,0, e_run("R9 run"));

    // R11: repeat the write-halt exactly
    pmode_i = 2'b10;
    do_halt(1, 16'hBEEF, 4'hA, 4'h5, "R11 repeat write-halt");
    cyc(0,1,0,0,0, e_wake(4'b0001, "R11 R7 repeat wake"));
    cyc(0,0,0,0,0, e_run("R11 run"));
    cyc(0,0,0,0,0, e_run("R1 steady run"));

    @(negedge clk_i);
    @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule